// File: doc/BRIEF.md
# Buck Controller Power-Up Sequencer

This block orders the power-up of a synchronous buck converter. While idle it watches the enable input, the supply-good indication from the undervoltage comparator, and the fault input. Once the converter is enabled, the supply is good and no fault is present, it runs a fixed measurement window. During that window the compensation node is driven to a set level so that an external classifier can sort the load on that node into a 2-bit sense code. On the last cycle of the window the sequencer turns the code into one of three short-circuit threshold selections and latches it.

Next comes a fixed hold. The compensation node is clamped low for this period so that the loop starts from a known state. After the hold the sequencer releases a stepped soft-start ramp code and raises a running flag. The low-side (rectifier) switch stays disabled until the PWM produces its first pulse. This means the converter only sources current while it starts into an output that is already pre-biased.

If enable drops, the supply goes bad or a fault is flagged, the sequencer returns to idle on the next cycle from any phase. The ramp is then cleared and the low-side switch is disabled. A new start always repeats the whole sequence from the measurement window. The analog measurement itself is outside this block.

Top module: `pwr_startup_seq`

## Requirements
- R1: While reset is asserted, meas_o, clamp_o, run_o and ls_en_o are 0, ramp_o is 0, and thr_sel_o is 2'b01 (the mid threshold).
- R2: From idle, the sequence starts only on a clock edge at which en_i=1, supply_ok_i=1 and fault_i=0. meas_o is high in the cycle that follows that edge.
- R3: meas_o stays high for exactly MEAS_CYCLES consecutive cycles, unless the sequence is aborted first.
- R4: On the edge that ends a completed measurement window, sense_code_i is decoded into thr_sel_o as follows: 2'b01 (heavy load, low resistance) gives 2'b00 (lowest threshold); 2'b10 (light load, higher resistance) gives 2'b10 (highest threshold); 2'b00 (open) and 2'b11 give 2'b01 (mid threshold). Only the code present on that final cycle counts.
- R5: thr_sel_o changes on no other edge. An abort, including one that cuts a window short, leaves thr_sel_o at its previous value.
- R6: clamp_o goes high right after the measurement window ends and stays high for exactly HOLD_CYCLES cycles.
- R7: After the hold, run_o stays high and ramp_o starts at 0. ramp_o goes up by one every STEP_CYCLES cycles and stays at all ones once it gets there. It never goes down while run_o is high.
- R8: ls_en_o is 0 until pwm_pulse_i has been sampled high on an edge at which run_o is high. It is 1 from the following cycle onward. Pulses during measurement or hold have no effect.
- R9: An edge at which en_i=0, supply_ok_i=0 or fault_i=1 returns the block to idle. In the next cycle meas_o, clamp_o, run_o, ls_en_o and ramp_o are all 0.
- R10: At most one of meas_o, clamp_o and run_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable (already resolved to logic level) |
| supply_ok_i | input | 1 | Supply above undervoltage lockout |
| fault_i | input | 1 | Fault request, forces idle |
| sense_code_i | input | 2 | Classified compensation-node load code |
| pwm_pulse_i | input | 1 | PWM high-side pulse indication |
| meas_o | output | 1 | Measurement mode: drive compensation node to test level |
| clamp_o | output | 1 | Hold compensation node low |
| thr_sel_o | output | 2 | Latched short-circuit threshold select |
| ramp_o | output | RAMP_W | Soft-start ramp code |
| ls_en_o | output | 1 | Low-side switch enable |
| run_o | output | 1 | Soft-start or regulation active |

## Verification
Any wrong internal phase or counter value shows up at the ports within one cycle. The phase flags would change one cycle early or late, or two would be high at once, and the comparison made on every clock catches that offset directly. If the wrong sense code is latched, or the latch is clobbered, thr_sel_o is wrong from the edge after the window ends, and it stays wrong until the next completed window. If the pulse-seen state is lost or set too early, ls_en_o is wrong in the cycle after the PWM pulse that was offered.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MEAS = 3'd1,
        ST_HOLD = 3'd2,
        ST_RAMP = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_e;

    // threshold select encoding seen by the protection comparator
    localparam logic [1:0] THR_LOW  = 2'b00;
    localparam logic [1:0] THR_MID  = 2'b01;
    localparam logic [1:0] THR_HIGH = 2'b10;

    // classifier codes
    localparam logic [1:0] SENSE_OPEN  = 2'b00;
    localparam logic [1:0] SENSE_HEAVY = 2'b01;
    localparam logic [1:0] SENSE_LIGHT = 2'b10;
endpackage

// File: rtl/sseq_thr_map.sv
module sseq_thr_map
    import sseq_pkg::*;
(
    input  logic [1:0] code_i,
    output logic [1:0] sel_o
);
    always_comb begin
        unique case (code_i)
            SENSE_HEAVY: sel_o = THR_LOW;
            SENSE_LIGHT: sel_o = THR_HIGH;
            SENSE_OPEN:  sel_o = THR_MID;
            default:     sel_o = THR_MID;
        endcase
    end
endmodule

// File: rtl/sseq_phase_timer.sv
module sseq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    assign done_o = run_i && !clear_i && (r_q.cnt == limit_i);

    always_comb begin
        r_d = r_q;
        if (clear_i || done_o) begin
            r_d.cnt = '0;
        end else if (run_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sseq_ramp.sv
module sseq_ramp #(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [RAMP_W-1:0] code_o,
    output logic              at_top_o
);
    localparam logic [RAMP_W-1:0] TOP = '1;

    typedef struct packed {
        logic [RAMP_W-1:0] code;
    } rmp_t;

    rmp_t r_d, r_q;

    assign code_o   = r_q.code;
    assign at_top_o = (r_q.code == TOP);

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.code = '0;
        end else if (step_i && !at_top_o) begin
            r_d.code = r_q.code + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pwr_startup_seq.sv
module pwr_startup_seq
    import sseq_pkg::*;
#(
    parameter int MEAS_CYCLES = 400000,
    parameter int HOLD_CYCLES = 800000,
    parameter int STEP_CYCLES = 3686,
    parameter int RAMP_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              supply_ok_i,
    input  logic              fault_i,
    input  logic [1:0]        sense_code_i,
    input  logic              pwm_pulse_i,
    output logic              meas_o,
    output logic              clamp_o,
    output logic [1:0]        thr_sel_o,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              ls_en_o,
    output logic              run_o
);
    localparam int MAX_A  = (MEAS_CYCLES > HOLD_CYCLES) ? MEAS_CYCLES : HOLD_CYCLES;
    localparam int MAX_B  = (MAX_A > STEP_CYCLES) ? MAX_A : STEP_CYCLES;
    localparam int CNT_W  = $clog2(MAX_B) + 1;
    localparam logic [CNT_W-1:0] LIM_MEAS = CNT_W'(MEAS_CYCLES - 1);
    localparam logic [CNT_W-1:0] LIM_HOLD = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] LIM_STEP = CNT_W'(STEP_CYCLES - 1);

    typedef struct packed {
        seq_state_e state;
        logic       seen;
        logic [1:0] thr;
    } seq_t;

    seq_t s_d, s_q;

    logic             abort;
    logic             tmr_run;
    logic [CNT_W-1:0] tmr_lim;
    logic             tmr_done;
    logic             ramp_step;
    logic             ramp_top;
    logic [1:0]       thr_new;
    logic             running;

    assign abort   = !en_i || !supply_ok_i || fault_i;
    assign running = (s_q.state == ST_RAMP) || (s_q.state == ST_RUN);

    always_comb begin
        tmr_run = 1'b0;
        tmr_lim = LIM_STEP;
        unique case (s_q.state)
            ST_MEAS: begin tmr_run = 1'b1; tmr_lim = LIM_MEAS; end
            ST_HOLD: begin tmr_run = 1'b1; tmr_lim = LIM_HOLD; end
            ST_RAMP: begin tmr_run = 1'b1; tmr_lim = LIM_STEP; end
            default: begin tmr_run = 1'b0; tmr_lim = LIM_STEP; end
        endcase
    end

    sseq_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (abort),
        .run_i   (tmr_run),
        .limit_i (tmr_lim),
        .done_o  (tmr_done)
    );

    assign ramp_step = (s_q.state == ST_RAMP) && tmr_done;

    sseq_ramp #(.RAMP_W(RAMP_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (abort || (s_q.state == ST_IDLE)),
        .step_i   (ramp_step),
        .code_o   (ramp_o),
        .at_top_o (ramp_top)
    );

    sseq_thr_map u_map (
        .code_i (sense_code_i),
        .sel_o  (thr_new)
    );

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.state = ST_IDLE;
            s_d.seen  = 1'b0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: s_d.state = ST_MEAS;
                ST_MEAS: if (tmr_done) begin
                    s_d.state = ST_HOLD;
                    s_d.thr   = thr_new;
                end
                ST_HOLD: if (tmr_done) s_d.state = ST_RAMP;
                ST_RAMP: if (ramp_top) s_d.state = ST_RUN;
                ST_RUN:  s_d.state = ST_RUN;
                default: s_d.state = ST_IDLE;
            endcase
            if (running && pwm_pulse_i) s_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.seen  <= 1'b0;
            s_q.thr   <= THR_MID;
        end else begin
            s_q <= s_d;
        end
    end

    assign meas_o    = (s_q.state == ST_MEAS);
    assign clamp_o   = (s_q.state == ST_HOLD);
    assign run_o     = running;
    assign ls_en_o   = s_q.seen;
    assign thr_sel_o = s_q.thr;
endmodule

// File: rtl/pwr_startup_seq_chk.sv
module pwr_startup_seq_chk #(
    parameter int RAMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              supply_ok_i,
    input logic              fault_i,
    input logic              meas_o,
    input logic              clamp_o,
    input logic [1:0]        thr_sel_o,
    input logic [RAMP_W-1:0] ramp_o,
    input logic              ls_en_o,
    input logic              run_o
);
    logic quit;
    logic idle;
    assign quit = !en_i || !supply_ok_i || fault_i;
    assign idle = !meas_o && !clamp_o && !run_o;

    assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({meas_o, clamp_o, run_o}));

    assert_ls_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en_o |-> run_o);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quit |=> (idle && !ls_en_o && ramp_o == '0));

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !quit) |=> meas_o);

    assert_thr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_o |=> $stable(thr_sel_o));

    assert_ramp_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> (!run_o || ramp_o >= $past(ramp_o)));
endmodule

bind pwr_startup_seq pwr_startup_seq_chk #(.RAMP_W(RAMP_W)) u_chk (.*);

// File: tb/pwr_startup_seq_test.sv
`timescale 1ns/1ps
module pwr_startup_seq_test;
    localparam int M    = 20;
    localparam int H    = 12;
    localparam int S    = 3;
    localparam int W    = 4;
    localparam int RMAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ok = 1'b0, flt = 1'b0, pwm = 1'b0;
    logic [1:0] sense = 2'b00;
    logic meas, clamp, ls, run;
    logic [1:0] thr;
    logic [W-1:0] ramp;

    always #2.5 clk = ~clk;

    pwr_startup_seq #(.MEAS_CYCLES(M), .HOLD_CYCLES(H), .STEP_CYCLES(S), .RAMP_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(ok), .fault_i(flt),
        .sense_code_i(sense), .pwm_pulse_i(pwm), .meas_o(meas), .clamp_o(clamp),
        .thr_sel_o(thr), .ramp_o(ramp), .ls_en_o(ls), .run_o(run)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // behavioural model: time since start decides the phase
    bit m_act = 0; int m_t = 0; bit m_seen = 0; logic [1:0] m_thr = 2'b01;

    function automatic logic [1:0] exp_map(logic [1:0] c);
        case (c)
            2'b01:   return 2'b00;
            2'b10:   return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 0; m_t <= 0; m_seen <= 0; m_thr <= 2'b01;
        end else if (!en || !ok || flt) begin
            m_act <= 0; m_t <= 0; m_seen <= 0;
        end else if (!m_act) begin
            m_act <= 1; m_t <= 0;
        end else begin
            if (m_t == M - 1) m_thr <= exp_map(sense);
            if (m_t >= M + H && pwm) m_seen <= 1;
            if (m_t < 1000000) m_t <= m_t + 1;
        end
    end

    function automatic int e_ramp();
        int v;
        if (!(m_act && m_t >= M + H)) return 0;
        v = (m_t - M - H) / S;
        return (v > RMAX) ? RMAX : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 meas_o",   meas,  int'(m_act && m_t < M));
            chk("R6 clamp_o",  clamp, int'(m_act && m_t >= M && m_t < M + H));
            chk("R7 run_o",    run,   int'(m_act && m_t >= M + H));
            chk("R7 ramp_o",   ramp,  e_ramp());
            chk("R8 ls_en_o",  ls,    int'(m_seen));
            chk("R4 thr_sel_o", thr,  m_thr);
            chk("R10 exclusive", int'($countones({meas, clamp, run}) <= 1), 1);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        cyc(3);
        chk("R1 reset meas", meas, 0);
        chk("R1 reset run", run, 0);
        chk("R1 reset ls", ls, 0);
        chk("R1 reset ramp", ramp, 0);
        chk("R1 reset thr", thr, 1);
        rst_n = 1'b1;
        ok = 1'b1;
        cyc(4);
        chk("R2 no start while disabled", meas, 0);
        // run A: heavy load code, early PWM pulses ignored
        sense = 2'b01; en = 1'b1; pwm = 1'b1;
        cyc(1);
        chk("R2 start", meas, 1);
        cyc(M + H - 2);
        pwm = 1'b0;
        cyc(2);
        chk("R8 ls off before pulse in run", ls, 0);
        cyc(RMAX * S + 10);
        chk("R7 ramp saturated", ramp, RMAX);
        pwm = 1'b1; cyc(1); pwm = 1'b0; cyc(2);
        chk("R8 ls on after pulse", ls, 1);
        en = 1'b0; cyc(1);
        chk("R9 abort by enable", int'({meas, clamp, run, ls}), 0);
        chk("R5 thr kept after abort", thr, 0);
        // run B: light load code, supply loss during hold
        en = 1'b1; sense = 2'b10;
        cyc(M + 4);
        chk("R4 light code latched", thr, 2);
        ok = 1'b0; cyc(1);
        chk("R9 abort by supply", int'({meas, clamp, run}), 0);
        ok = 1'b1;
        // run C: fault inside window, no latch
        sense = 2'b11;
        cyc(10);
        flt = 1'b1; cyc(1); flt = 1'b0;
        chk("R5 thr untouched by cut window", thr, 2);
        // run D: code changing every cycle, pulse mid-ramp, fault in ramp
        for (int i = 0; i < M + 2; i++) begin
            sense = 2'(i * 3 + 1);
            cyc(1);
        end
        cyc(H + 4);
        pwm = 1'b1; cyc(1); pwm = 1'b0;
        cyc(6);
        flt = 1'b1; cyc(1); flt = 1'b0;
        chk("R9 abort by fault", int'(ramp), 0);
        // run E: invalid code maps to mid
        sense = 2'b11;
        cyc(M + 2);
        chk("R4 code 3 maps to mid", thr, 1);
        cyc(H + 5);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        summary();
        $finish;
    end
endmodule